// File: doc/BRIEF.md
# Burst Address Sequencer

This block holds the word address of a synchronous burst memory and produces the address sequence of a burst. A cycle with the advance strobe low loads a full external address. Each cycle with the advance strobe high moves the burst one step. A step changes only the two lowest address bits, and the upper bits stay as they were. An order-select input chooses how the low bits move: an interleaved order, where the start bits are XORed with a step count, or a linear order that counts upward and wraps modulo four. A hold input freezes the block completely, so a burst can be stalled and then resumed where it stopped.

The current address and a flag are both registered. The flag tells whether the present address came from a load or from a burst step. The memory array, the data path and chip-select decoding lie outside this block.

Top module: `bseq_burst_addr`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) sets `addr_out` to zero and `is_load` to 0 after that edge.
- R2: With `hold` low and `adv` low at a rising edge, `addr_out` equals the `addr_in` sampled at that edge, and `is_load` is 1.
- R3: With `hold` low and `adv` high at a rising edge, `addr_in` has no effect. Bits [17:2] of `addr_out` keep their value and `is_load` is 0.
- R4: When `order_il` is 1, the low two bits on the k-th step after a load equal the loaded low bits XOR (k mod 4). From a start of 01 this gives 01, 00, 11, 10.
- R5: When `order_il` is 0, the low two bits on the k-th step after a load equal (loaded low bits + k) mod 4. From a start of 10 this gives 10, 11, 00, 01.
- R6: The fourth step after a load returns the low bits to the loaded value, and stepping goes on through the same cycle of four.
- R7: With `hold` high at a rising edge, `addr_out` and `is_load` keep their values whatever `adv` and `addr_in` carry. A burst interrupted this way resumes at the next step of its sequence.
- R8: A load during a burst restarts the step count. The first step after it yields the new start bits moved by one step.
- R9: When `hold` is high and `adv` is low in the same cycle, no load takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hold | input | 1 | 1 freezes all state for the cycle |
| adv | input | 1 | 1 advances the burst, 0 loads `addr_in` |
| order_il | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addr_in | input | 18 | External word address |
| addr_out | output | 18 | Current internal address |
| is_load | output | 1 | 1 when `addr_out` came from a load, 0 after a burst step or reset |

## Verification
Hold and load can both be requested in the same cycle: the hold input is high while the advance strobe is low and a new address sits on `addr_in`. The bench raises both in the middle of every burst in both orders, and on the first cycle after a load. It then checks that the address and the flag stay exactly as they were, and that the next step still follows the interrupted sequence. A hold that arrives together with an advance request is tested the same way.

// File: rtl/bseq_pkg.sv
// Package for the burst address sequencer.
// It defines the command that the controller decodes for each cycle.
package bseq_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } bseq_cmd_e;
endpackage

// File: rtl/bseq_ctrl.sv
// Command decoder. It maps hold and adv onto one command per cycle.
// Assumes: hold takes precedence over both load and step.
module bseq_ctrl
    import bseq_pkg::*;
(
    input  logic      hold,
    input  logic      adv,
    output bseq_cmd_e cmd
);
    // Pick the command; hold wins over everything else.
    always_comb begin
        if (hold)
            cmd = CMD_HOLD;
        else if (adv)
            cmd = CMD_STEP;
        else
            cmd = CMD_LOAD;
    end
endmodule

// File: rtl/bseq_step_gen.sv
// Next-step generator for the low burst bits.
// It produces the next step count and the low bits that count selects,
// in interleaved (start XOR count) or linear (start + count, wrapping) order.
// Assumes: the order select is static, and its current value is used.
module bseq_step_gen #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] start_low,
    input  logic [BURST_W-1:0] step_cnt,
    input  logic               interleaved,
    output logic [BURST_W-1:0] cnt_nxt,
    output logic [BURST_W-1:0] low_nxt
);
    logic [BURST_W-1:0] il_low;
    logic [BURST_W-1:0] ln_low;

    // Step count wraps naturally at 2**BURST_W.
    assign cnt_nxt = step_cnt + BURST_W'(1);

    // Both orders are formed and the select picks one.
    assign il_low  = start_low ^ cnt_nxt;
    assign ln_low  = start_low + cnt_nxt;
    assign low_nxt = interleaved ? il_low : ln_low;
endmodule

// File: rtl/bseq_regs.sv
// State registers: address, burst start bits, step count and load flag.
// Assumes: a synchronous active-low reset; the low BURST_W address bits
// take part in bursts and the upper bits are only ever loaded.
module bseq_regs
    import bseq_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bseq_cmd_e          cmd,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic [BURST_W-1:0] cnt_nxt,
    input  logic [BURST_W-1:0] low_nxt,
    output logic [ADDR_W-1:0]  addr_q,
    output logic [BURST_W-1:0] start_q,
    output logic [BURST_W-1:0] cnt_q,
    output logic               load_q
);
    localparam int UPPER_W = ADDR_W - BURST_W;

    // Update the state by command; CMD_HOLD leaves all of it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            load_q  <= 1'b0;
        end else begin
            case (cmd)
                CMD_LOAD: begin
                    addr_q  <= addr_in;
                    start_q <= addr_in[BURST_W-1:0];
                    cnt_q   <= '0;
                    load_q  <= 1'b1;
                end
                CMD_STEP: begin
                    addr_q  <= {addr_q[ADDR_W-1 -: UPPER_W], low_nxt};
                    cnt_q   <= cnt_nxt;
                    load_q  <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bseq_burst_addr.sv
// Top of the burst address sequencer.
// It loads a word address, or steps the low bits in the selected burst
// order, and freezes completely while hold is high.
// Assumes: order_il is quasi-static and sampled without synchronisation.
module bseq_burst_addr
    import bseq_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              adv,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              is_load
);
    bseq_cmd_e          cmd;
    logic [BURST_W-1:0] start_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nxt;
    logic [BURST_W-1:0] low_nxt;

    // Decode the cycle command.
    bseq_ctrl ctrl_i (
        .hold (hold),
        .adv  (adv),
        .cmd  (cmd)
    );

    // Form the next burst position.
    bseq_step_gen #(.BURST_W(BURST_W)) step_i (
        .start_low   (start_q),
        .step_cnt    (cnt_q),
        .interleaved (order_il),
        .cnt_nxt     (cnt_nxt),
        .low_nxt     (low_nxt)
    );

    // Hold the address state.
    bseq_regs #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .addr_in (addr_in),
        .cnt_nxt (cnt_nxt),
        .low_nxt (low_nxt),
        .addr_q  (addr_out),
        .start_q (start_q),
        .cnt_q   (cnt_q),
        .load_q  (is_load)
    );
endmodule

// File: rtl/bseq_burst_addr_chk.sv
// Checker for the burst address sequencer, bound to the top module.
// It observes only the ports of the top.
module bseq_burst_addr_chk #(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              adv,
    input logic              order_il,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              is_load
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (addr_out == '0) && !is_load);

    // R2
    load_takes_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !adv) |=> (addr_out == $past(addr_in)) && is_load);

    // R3
    step_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && adv) |=> (addr_out[ADDR_W-1:BURST_W] == $past(addr_out[ADDR_W-1:BURST_W])) && !is_load);

    // R4
    il_first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && !hold && adv && order_il) |=>
        (addr_out[BURST_W-1:0] == ($past(addr_out[BURST_W-1:0]) ^ BURST_W'(1))));

    // R5
    ln_first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && !hold && adv && !order_il) |=>
        (addr_out[BURST_W-1:0] == BURST_W'($past(addr_out[BURST_W-1:0]) + BURST_W'(1))));

    // R7
    hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(addr_out) && $stable(is_load));
endmodule

bind bseq_burst_addr bseq_burst_addr_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .adv      (adv),
    .order_il (order_il),
    .addr_in  (addr_in),
    .addr_out (addr_out),
    .is_load  (is_load)
);

// File: tb/bseq_burst_addr_tb_top.sv
// Self-checking bench: it sweeps both orders and every start value, with
// holds, ignored addresses, wraps and mid-burst reloads.
module bseq_burst_addr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b0;
    logic        adv = 1'b0;
    logic        order_il = 1'b0;
    logic [17:0] addr_in = '0;
    logic [17:0] addr_out;
    logic        is_load;

    int checks = 0;
    int errors = 0;

    always #4ns clk = ~clk;

    bseq_burst_addr dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .adv      (adv),
        .order_il (order_il),
        .addr_in  (addr_in),
        .addr_out (addr_out),
        .is_load  (is_load)
    );

    // Drive at the falling edge, then sample just after the rising edge.
    task automatic cyc(input logic r, input logic h, input logic a, input logic [17:0] ad);
        @(negedge clk);
        rst_n = r; hold = h; adv = a; addr_in = ad;
        @(posedge clk);
        #1ns;
    endtask

    task automatic chk(input string req, input logic [17:0] exp_a, input logic exp_l);
        checks++;
        if (addr_out !== exp_a || is_load !== exp_l) begin
            errors++;
            $display("FAIL %s: addr=%h load=%b expected addr=%h load=%b",
                     req, addr_out, is_load, exp_a, exp_l);
        end
    endtask

    function automatic logic [1:0] seq_low(input logic il, input logic [1:0] s, input int k);
        return il ? (s ^ 2'(k % 4)) : 2'((int'(s) + k) % 4);
    endfunction

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [17:0] base;
        logic [17:0] exp_a;
        cyc(1'b0, 1'b0, 1'b0, 18'h3ffff);
        cyc(1'b0, 1'b0, 1'b1, 18'h12345);
        chk("R1 reset", 18'h0, 1'b0);

        for (int ord = 0; ord < 2; ord++) begin
            order_il = ord[0];
            for (int s = 0; s < 4; s++) begin
                base = {16'(ord * 977 + s * 4133 + 5), 2'(s)};
                cyc(1'b1, 1'b0, 1'b0, base);
                chk("R2 load", base, 1'b1);
                // R9: hold with a load request right after the load
                cyc(1'b1, 1'b1, 1'b0, ~base);
                chk("R9 hold beats load", base, 1'b1);
                for (int k = 1; k <= 9; k++) begin
                    exp_a = {base[17:2], seq_low(ord[0], 2'(s), k - 1)};
                    if (k == 3) begin
                        cyc(1'b1, 1'b1, 1'b0, base ^ 18'h2aaaa);
                        chk("R9 hold with load", exp_a, 1'b0);
                    end
                    if (k == 6) begin
                        cyc(1'b1, 1'b1, 1'b1, 18'h0);
                        chk("R7 hold with advance", exp_a, 1'b0);
                    end
                    cyc(1'b1, 1'b0, 1'b1, ~base);
                    exp_a = {base[17:2], seq_low(ord[0], 2'(s), k)};
                    if (ord == 1)
                        chk("R4 interleaved step (R3 upper kept)", exp_a, 1'b0);
                    else
                        chk("R5 linear step (R3 upper kept)", exp_a, 1'b0);
                    if (k == 4 || k == 8)
                        chk("R6 wrap to start", base, 1'b0);
                end
                // R8: reload in mid-burst
                cyc(1'b1, 1'b0, 1'b1, 18'h0);
                cyc(1'b1, 1'b0, 1'b0, base ^ 18'h15553);
                chk("R8 reload", base ^ 18'h15553, 1'b1);
                cyc(1'b1, 1'b0, 1'b1, base);
                exp_a = base ^ 18'h15553;
                exp_a[1:0] = seq_low(ord[0], exp_a[1:0], 1);
                chk("R8 restart count", exp_a, 1'b0);
            end
        end

        // Known sequences given in the requirements
        order_il = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, 18'h00001);
        cyc(1'b1, 1'b0, 1'b1, 18'h0);
        chk("R4 01->00", 18'h00000, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 18'h0);
        chk("R4 00->11", 18'h00003, 1'b0);
        order_il = 1'b0;
        cyc(1'b1, 1'b0, 1'b0, 18'h00002);
        cyc(1'b1, 1'b0, 1'b1, 18'h0);
        cyc(1'b1, 1'b0, 1'b1, 18'h0);
        chk("R5 10->11->00", 18'h00000, 1'b0);

        // R1: reset in mid-operation
        cyc(1'b0, 1'b0, 1'b1, 18'h3ffff);
        chk("R1 reset mid-burst", 18'h0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule